// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when a 1024-row asynchronous DRAM must be refreshed and drives the row and column strobes for those refreshes. It leaves reset in a power-up wait. It then runs a fixed number of initialization refreshes in which CAS falls before RAS. After that it raises one distributed refresh request every interval, and it enters and leaves self refresh when the host asks. It shares the strobes with an access sequencer through a request/grant pair. It drives RAS and CAS only after the sequencer has granted its request.

A self-refresh entry is bracketed. The block first runs one ordinary CAS-before-RAS refresh. It then holds RAS low for at least the minimum self-refresh time, even if the host withdraws its request early, so RAS low times in the forbidden middle band never occur. On exit, CAS is held after RAS rises, the longer self-refresh precharge is observed, and one more ordinary refresh runs before control returns. A tally of ordinary refreshes since the last exit blocks a new entry until every row has been refreshed again. A refresh request that is still waiting when the next one falls due sets a sticky overdue flag.

All times are given in clock cycles as parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n and cas_n are high, req, init_done, sr_active and overdue_err are low, and sr_allowed is high.
- R2: After reset is released, req stays low and no strobe is driven for PWRUP_CYC clock edges. req rises at exactly the PWRUP_CYC-th edge.
- R3: Exactly INIT_REFS CAS-before-RAS refreshes are completed before init_done rises. Once init_done is high it stays high until reset.
- R4: In every refresh, cas_n is low for at least CSR_CYC cycles with ras_n high before ras_n falls, and cas_n stays low for the whole time ras_n is low. An ordinary refresh holds ras_n low for exactly RAS_LOW_CYC cycles. ras_n stays high for at least RP_CYC cycles between pulses.
- R5: ras_n or cas_n is low only while both req and gnt are high. A pending refresh waits, with req held high, for as long as gnt stays low.
- R6: After init_done, in normal operation, successive rising edges of req caused by the interval timer are exactly INTERVAL_CYC cycles apart.
- R7: If a refresh request is still not granted when the next interval expires, overdue_err rises. overdue_err stays high until reset.
- R8: When sr_want is high, sr_allowed is high and gnt is given, sr_active rises. The block runs exactly one ordinary refresh and then the self-refresh pulse. A periodic request that falls due in the same cycle as the entry grant is served by that refresh, and no extra refresh follows the exit.
- R9: A self-refresh pulse holds ras_n low for at least SELF_MIN_CYC cycles. If sr_want is already low, the pulse ends after exactly SELF_MIN_CYC cycles. No ras_n low width lies strictly between RAS_LOW_CYC and SELF_MIN_CYC.
- R10: After the self-refresh pulse, cas_n stays low for exactly CHS_CYC cycles after ras_n rises. ras_n then stays high for at least CHS_CYC+RPS_CYC cycles before the next fall. Exactly one ordinary refresh runs before sr_active falls.
- R11: After a self-refresh exit, sr_allowed is low and no new entry starts until ROWS ordinary periodic refreshes have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_want | input | 1 | Host level: high asks for self refresh, low asks to leave it |
| gnt | input | 1 | Grant from the access sequencer, held while req is high |
| req | output | 1 | Request for the strobes |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| init_done | output | 1 | Power-up sequence complete |
| sr_active | output | 1 | Self-refresh bracket (entry refresh, pulse, exit refresh) in progress |
| sr_allowed | output | 1 | Whole array refreshed since the last exit |
| overdue_err | output | 1 | Sticky: a refresh waited longer than one interval |

## Verification
The periodic interval timer and a self-refresh entry can fall due in the same clock edge. In that case the scheduler must serve both with one refresh and must not queue a second one. The bench provokes this by holding gnt low while sr_want is high, then granting on the half cycle before the edge at which its own count predicts the next interval expiry. The run passes if exactly one ordinary refresh precedes the self-refresh pulse, exactly one follows it, no further refresh occurs during the following interval, and overdue_err stays low.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_INIT_REQ,
      ST_INIT_BUSY,
      ST_IDLE,
      ST_RF_BUSY,
      ST_SR_PRE,
      ST_SR_IN,
      ST_SR_POST
   } sched_state_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_HOLD,
      PH_PRECH
   } pulse_phase_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_tick_timer.sv
// Free-running modulo counter; tick in the last cycle of each period.
module rfsh_tick_timer #(
   parameter int unsigned LIMIT = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("rfsh_tick_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign tick = !clear && (cnt_q == W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rfsh_row_tally.sv
// Saturating count of ordinary refreshes since the last self-refresh exit.
module rfsh_row_tally #(
   parameter int unsigned ROWS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic full
);
   localparam int unsigned W = $clog2(ROWS + 1);

   logic [W-1:0] cnt_q;

   assign full = (cnt_q == W'(ROWS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= W'(ROWS);
      else if (clear)          cnt_q <= '0;
      else if (inc && !full)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rfsh_cbr_engine.sv
// Generates one CAS-before-RAS strobe sequence, ordinary or self refresh.
module rfsh_cbr_engine
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned CSR_CYC      = 1,
   parameter int unsigned RAS_LOW_CYC  = 7,
   parameter int unsigned RP_CYC       = 5,
   parameter int unsigned SELF_MIN_CYC = 10000,
   parameter int unsigned CHS_CYC      = 5,
   parameter int unsigned RPS_CYC      = 13,
   parameter bit          REG_STROBES  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic self_mode,
   input  logic exit_ok,
   output logic done,
   output logic ras_n,
   output logic cas_n
);
   localparam int unsigned MAXC = umax(umax(umax(CSR_CYC, RAS_LOW_CYC), umax(RP_CYC, SELF_MIN_CYC)),
                                       umax(CHS_CYC, RPS_CYC));
   localparam int unsigned CW   = $clog2(MAXC + 1);

   pulse_phase_e  phase_q;
   logic [CW-1:0] cnt_q;
   logic          self_q;
   logic          cnt_zero;
   logic          ras_d, cas_d;

   assign cnt_zero = (cnt_q == '0);
   assign done     = (phase_q == PH_PRECH) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         self_q  <= 1'b0;
      end else if (start && (phase_q == PH_IDLE || done)) begin
         phase_q <= PH_SETUP;
         cnt_q   <= CW'(CSR_CYC - 1);
         self_q  <= self_mode;
      end else begin
         case (phase_q)
            PH_SETUP: begin
               if (cnt_zero) begin
                  phase_q <= PH_ACTIVE;
                  cnt_q   <= self_q ? CW'(SELF_MIN_CYC - 1) : CW'(RAS_LOW_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_ACTIVE: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (!self_q) begin
                  phase_q <= PH_PRECH;
                  cnt_q   <= CW'(RP_CYC - 1);
               end else if (exit_ok) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= CW'(CHS_CYC - 1);
               end
            end
            PH_HOLD: begin
               if (cnt_zero) begin
                  phase_q <= PH_PRECH;
                  cnt_q   <= CW'(RPS_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_PRECH: begin
               if (cnt_zero) phase_q <= PH_IDLE;
               else          cnt_q   <= cnt_q - 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign ras_d = (phase_q != PH_ACTIVE);
   assign cas_d = !(phase_q == PH_SETUP || phase_q == PH_ACTIVE || phase_q == PH_HOLD);

   generate
      if (REG_STROBES) begin : g_reg_strobes
         logic ras_q, cas_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ras_q <= 1'b1;
               cas_q <= 1'b1;
            end else begin
               ras_q <= ras_d;
               cas_q <= cas_d;
            end
         end
         assign ras_n = ras_q;
         assign cas_n = cas_q;
      end else begin : g_comb_strobes
         assign ras_n = ras_d;
         assign cas_n = cas_d;
      end
   endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned ROWS         = 1024,
   parameter int unsigned PWRUP_CYC    = 10000,
   parameter int unsigned INIT_REFS    = 8,
   parameter int unsigned INTERVAL_CYC = 1560,
   parameter int unsigned CSR_CYC      = 1,
   parameter int unsigned CHR_CYC      = 1,
   parameter int unsigned RAS_LOW_CYC  = 7,
   parameter int unsigned RP_CYC       = 5,
   parameter int unsigned SELF_MIN_CYC = 10000,
   parameter int unsigned CHS_CYC      = 5,
   parameter int unsigned RPS_CYC      = 13,
   parameter bit          REG_STROBES  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sr_want,
   input  logic gnt,
   output logic req,
   output logic ras_n,
   output logic cas_n,
   output logic init_done,
   output logic sr_active,
   output logic sr_allowed,
   output logic overdue_err
);
   localparam int unsigned IW       = $clog2(INIT_REFS + 1);
   localparam int unsigned CBR_SPAN = 1 + CSR_CYC + RAS_LOW_CYC + RP_CYC;

   generate
      if (INIT_REFS < 1) begin : g_chk_init
         $error("dram_refresh_sched: INIT_REFS must be at least 1");
      end
      if (CSR_CYC < 1 || CHS_CYC < 1 || RP_CYC < 1 || RPS_CYC < 1 || RAS_LOW_CYC < 1) begin : g_chk_min
         $error("dram_refresh_sched: every phase needs at least one cycle");
      end
      if (CHR_CYC > RAS_LOW_CYC) begin : g_chk_chr
         $error("dram_refresh_sched: CAS hold after RAS fall exceeds RAS low time");
      end
      if (SELF_MIN_CYC <= RAS_LOW_CYC) begin : g_chk_self
         $error("dram_refresh_sched: self-refresh minimum must exceed ordinary RAS low time");
      end
      if (INTERVAL_CYC <= CBR_SPAN) begin : g_chk_iv
         $error("dram_refresh_sched: interval shorter than one refresh");
      end
   endgenerate

   sched_state_e  state_q, state_d;
   logic [IW-1:0] init_left_q;
   logic          init_done_q;
   logic          pending_q;
   logic          overdue_q;
   logic          pw_tick, iv_tick;
   logic          run_mode;
   logic          want_sr;
   logic          eng_start, eng_self, eng_done;
   logic          idle_start, start_sr;

   assign run_mode = (state_q == ST_IDLE) || (state_q == ST_RF_BUSY);
   assign want_sr  = sr_want && sr_allowed;

   rfsh_tick_timer #(.LIMIT(PWRUP_CYC)) u_pwrup_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q != ST_PWRUP),
      .tick  (pw_tick)
   );

   rfsh_tick_timer #(.LIMIT(INTERVAL_CYC)) u_interval_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!run_mode),
      .tick  (iv_tick)
   );

   rfsh_row_tally #(.ROWS(ROWS)) u_row_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .clear ((state_q == ST_SR_POST) && eng_done),
      .inc   ((state_q == ST_RF_BUSY) && eng_done),
      .full  (sr_allowed)
   );

   rfsh_cbr_engine #(
      .CSR_CYC      (CSR_CYC),
      .RAS_LOW_CYC  (RAS_LOW_CYC),
      .RP_CYC       (RP_CYC),
      .SELF_MIN_CYC (SELF_MIN_CYC),
      .CHS_CYC      (CHS_CYC),
      .RPS_CYC      (RPS_CYC),
      .REG_STROBES  (REG_STROBES)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (eng_start),
      .self_mode (eng_self),
      .exit_ok   (!sr_want),
      .done      (eng_done),
      .ras_n     (ras_n),
      .cas_n     (cas_n)
   );

   always_comb begin
      state_d   = state_q;
      eng_start = 1'b0;
      eng_self  = 1'b0;
      case (state_q)
         ST_PWRUP: begin
            if (pw_tick) state_d = ST_INIT_REQ;
         end
         ST_INIT_REQ: begin
            if (gnt) begin
               eng_start = 1'b1;
               state_d   = ST_INIT_BUSY;
            end
         end
         ST_INIT_BUSY: begin
            if (eng_done) state_d = (init_left_q == IW'(1)) ? ST_IDLE : ST_INIT_REQ;
         end
         ST_IDLE: begin
            if (gnt && want_sr) begin
               eng_start = 1'b1;
               state_d   = ST_SR_PRE;
            end else if (gnt && pending_q) begin
               eng_start = 1'b1;
               state_d   = ST_RF_BUSY;
            end
         end
         ST_RF_BUSY: begin
            if (eng_done) state_d = ST_IDLE;
         end
         ST_SR_PRE: begin
            if (eng_done) begin
               eng_start = 1'b1;
               eng_self  = 1'b1;
               state_d   = ST_SR_IN;
            end
         end
         ST_SR_IN: begin
            if (eng_done) begin
               eng_start = 1'b1;
               state_d   = ST_SR_POST;
            end
         end
         ST_SR_POST: begin
            if (eng_done) state_d = ST_IDLE;
         end
         default: state_d = ST_PWRUP;
      endcase
   end

   assign idle_start = (state_q == ST_IDLE) && eng_start;
   assign start_sr   = idle_start && (state_d == ST_SR_PRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_PWRUP;
         init_left_q <= IW'(INIT_REFS);
         init_done_q <= 1'b0;
         pending_q   <= 1'b0;
         overdue_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_INIT_BUSY && eng_done) begin
            init_left_q <= init_left_q - 1'b1;
            if (init_left_q == IW'(1)) init_done_q <= 1'b1;
         end
         if (start_sr) pending_q <= 1'b0;
         else          pending_q <= iv_tick || (pending_q && !idle_start);
         if (iv_tick && pending_q && !idle_start) overdue_q <= 1'b1;
      end
   end

   assign req = ((state_q != ST_PWRUP) && (state_q != ST_IDLE)) ||
                ((state_q == ST_IDLE) && (pending_q || want_sr));
   assign init_done   = init_done_q;
   assign sr_active   = (state_q == ST_SR_PRE) || (state_q == ST_SR_IN) || (state_q == ST_SR_POST);
   assign overdue_err = overdue_q;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
   parameter int unsigned RAS_LOW_CYC  = 7,
   parameter int unsigned SELF_MIN_CYC = 10000
) (
   input logic clk,
   input logic rst_n,
   input logic gnt,
   input logic req,
   input logic ras_n,
   input logic cas_n,
   input logic init_done,
   input logic sr_active,
   input logic sr_allowed,
   input logic overdue_err
);
   logic [31:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_run <= '0;
      else if (!ras_n) low_run <= low_run + 1;
      else             low_run <= '0;
   end

   // R4
   cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

   // R4
   cas_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);

   // R5
   strobe_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> (req && gnt));

   // R3
   init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R7
   overdue_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overdue_err |=> overdue_err);

   // R9
   ras_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> ((low_run == RAS_LOW_CYC) || (low_run >= SELF_MIN_CYC)));

   // R11
   entry_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_active) |-> $past(sr_allowed));
endmodule

bind dram_refresh_sched rfsh_sched_chk #(
   .RAS_LOW_CYC  (RAS_LOW_CYC),
   .SELF_MIN_CYC (SELF_MIN_CYC)
) u_sched_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gnt         (gnt),
   .req         (req),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .init_done   (init_done),
   .sr_active   (sr_active),
   .sr_allowed  (sr_allowed),
   .overdue_err (overdue_err)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ROWS     = 8;
   localparam int PWRUP    = 20;
   localparam int INITN    = 8;
   localparam int INTERVAL = 40;
   localparam int CSR      = 2;
   localparam int RASLOW   = 4;
   localparam int RP       = 3;
   localparam int SELFMIN  = 30;
   localparam int CHS      = 2;
   localparam int RPS      = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sr_want = 1'b0;
   logic gnt = 1'b0;
   logic req, ras_n, cas_n, init_done, sr_active, sr_allowed, overdue_err;

   logic auto_gnt = 1'b1;
   logic force_gnt = 1'b0;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   // monitor state
   int norm_cnt = 0, self_cnt = 0, shape_err = 0;
   int low_run = 0, high_run = 0, lead_run = 0, hold_run = 0;
   int last_norm_width = 0, last_self_width = 0, last_lead = 0, last_high = 0;
   int last_hold = 0, high_after_self = 0;
   bit after_self = 1'b0, hold_live = 1'b0;
   int first_req_cyc = -1, req_rises = 0, last_rise = 0, prev_rise = 0;
   logic prev_ras = 1'b1, prev_req = 1'b0;

   dram_refresh_sched #(
      .ROWS(ROWS), .PWRUP_CYC(PWRUP), .INIT_REFS(INITN), .INTERVAL_CYC(INTERVAL),
      .CSR_CYC(CSR), .CHR_CYC(1), .RAS_LOW_CYC(RASLOW), .RP_CYC(RP),
      .SELF_MIN_CYC(SELFMIN), .CHS_CYC(CHS), .RPS_CYC(RPS), .REG_STROBES(1'b1)
   ) u_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .sr_want(sr_want), .gnt(gnt), .req(req),
      .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done), .sr_active(sr_active),
      .sr_allowed(sr_allowed), .overdue_err(overdue_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   always @(negedge clk) gnt <= auto_gnt ? req : force_gnt;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((!ras_n || !cas_n) && !(req && gnt)) shape_err++;
         if (!ras_n && cas_n) shape_err++;
         if (req && first_req_cyc < 0) first_req_cyc = cyc;
         if (req && !prev_req) begin
            prev_rise = last_rise;
            last_rise = cyc;
            req_rises++;
         end
         if (ras_n && !prev_ras) begin
            if (low_run >= SELFMIN) begin
               self_cnt++;
               last_self_width = low_run;
               after_self = 1'b1;
               hold_live = 1'b1;
               hold_run = 0;
               high_run = 0;
            end else begin
               norm_cnt++;
               last_norm_width = low_run;
               if (low_run != RASLOW) shape_err++;
            end
            low_run = 0;
         end
         if (!ras_n && prev_ras) begin
            last_lead = lead_run;
            last_high = high_run;
            if (after_self) begin
               high_after_self = high_run;
               after_self = 1'b0;
            end
            if (lead_run < CSR) shape_err++;
            high_run = 0;
         end
         if (hold_live) begin
            if (!cas_n && ras_n) hold_run++;
            else begin
               last_hold = hold_run;
               hold_live = 1'b0;
            end
         end
         if (ras_n) high_run++; else low_run++;
         if (ras_n && !cas_n) lead_run++; else lead_run = 0;
         prev_ras = ras_n;
         prev_req = req;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   task automatic t_reset();
      step(3);
      chk(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
      chk(!req && !init_done && !sr_active && !overdue_err, "R1 outputs",
          {req, init_done, sr_active, overdue_err}, 0);
      chk(sr_allowed, "R1 sr_allowed", sr_allowed, 1);
   endtask

   task automatic t_powerup();
      rst_n = 1'b1;
      for (int i = 0; i < PWRUP + 5 && first_req_cyc < 0; i++) step();
      chk(first_req_cyc == PWRUP, "R2 req rise cycle", first_req_cyc, PWRUP);
      chk(norm_cnt == 0, "R2 no strobe during wait", norm_cnt, 0);
   endtask

   task automatic t_init();
      for (int i = 0; i < 400 && !init_done; i++) step();
      chk(norm_cnt == INITN, "R3 init refresh count", norm_cnt, INITN);
      chk(last_norm_width == RASLOW, "R4 ras low width", last_norm_width, RASLOW);
      chk(last_lead >= CSR, "R4 cas lead", last_lead, CSR);
      chk(last_high >= RP, "R4 precharge", last_high, RP);
      step(5);
      chk(init_done, "R3 init_done held", init_done, 1);
   endtask

   task automatic t_interval();
      int r0;
      r0 = req_rises;
      for (int i = 0; i < 200 && req_rises < r0 + 3; i++) step();
      chk(last_rise - prev_rise == INTERVAL, "R6 interval", last_rise - prev_rise, INTERVAL);
      chk(shape_err == 0, "R4 shape", shape_err, 0);
   endtask

   task automatic t_grant_wait();
      int n0, r0;
      for (int i = 0; i < 100 && req; i++) step();
      auto_gnt = 1'b0;
      r0 = req_rises;
      for (int i = 0; i < 100 && req_rises == r0; i++) step();
      n0 = norm_cnt;
      step(10);
      chk(norm_cnt == n0 && ras_n && cas_n, "R5 waits for gnt", norm_cnt, n0);
      chk(req, "R5 req held", req, 1);
      auto_gnt = 1'b1;
      step(20);
      chk(norm_cnt == n0 + 1, "R5 served after gnt", norm_cnt, n0 + 1);
      chk(!overdue_err, "R7 no overdue on short wait", overdue_err, 0);
   endtask

   task automatic t_self_refresh();
      int target, n0, s0;
      for (int i = 0; i < 100 && req; i++) step();
      target = last_rise + INTERVAL;
      while (target - 1 <= cyc + 2) target += INTERVAL;
      auto_gnt = 1'b0;
      force_gnt = 1'b0;
      n0 = norm_cnt;
      s0 = self_cnt;
      sr_want = 1'b1;
      while (cyc < target - 1) step();
      force_gnt = 1'b1;
      for (int i = 0; i < 100 && norm_cnt == n0; i++) step();
      chk(sr_active, "R8 sr_active", sr_active, 1);
      sr_want = 1'b0;
      for (int i = 0; i < 400 && sr_active; i++) step();
      chk(self_cnt == s0 + 1, "R8 one self pulse", self_cnt, s0 + 1);
      chk(norm_cnt == n0 + 2, "R8 one refresh each side", norm_cnt, n0 + 2);
      chk(last_self_width == SELFMIN, "R9 self width", last_self_width, SELFMIN);
      chk(last_hold == CHS, "R10 cas hold after exit", last_hold, CHS);
      chk(high_after_self >= CHS + RPS, "R10 self precharge", high_after_self, CHS + RPS);
      force_gnt = 1'b0;
      auto_gnt = 1'b1;
      n0 = norm_cnt;
      step(INTERVAL - 4);
      chk(norm_cnt == n0, "R8 no extra refresh after coincident tick", norm_cnt, n0);
      chk(!overdue_err, "R8 no overdue", overdue_err, 0);
      chk(shape_err == 0, "R4 shape during self refresh", shape_err, 0);
   endtask

   task automatic t_reentry();
      int n0;
      chk(!sr_allowed, "R11 blocked after exit", sr_allowed, 0);
      n0 = norm_cnt;
      sr_want = 1'b1;
      for (int i = 0; i < 2000 && !sr_active; i++) step();
      chk(norm_cnt - n0 == ROWS, "R11 refreshes before re-entry", norm_cnt - n0, ROWS);
      sr_want = 1'b0;
      for (int i = 0; i < 400 && sr_active; i++) step();
      chk(!sr_active && !sr_allowed, "R11 exit again", {sr_active, sr_allowed}, 0);
   endtask

   task automatic t_overdue();
      int n0;
      for (int i = 0; i < 100 && req; i++) step();
      chk(!overdue_err, "R7 clear before test", overdue_err, 0);
      auto_gnt = 1'b0;
      step(2 * INTERVAL + 5);
      chk(overdue_err, "R7 overdue set", overdue_err, 1);
      n0 = norm_cnt;
      auto_gnt = 1'b1;
      step(INTERVAL + 5);
      chk(overdue_err, "R7 overdue sticky", overdue_err, 1);
      chk(norm_cnt > n0, "R5 refresh resumes", norm_cnt, n0 + 1);
      chk(shape_err == 0, "R5 strobes only when granted", shape_err, 0);
   endtask

   initial begin
      t_reset();
      t_powerup();
      t_init();
      t_interval();
      t_grant_wait();
      t_self_refresh();
      t_reentry();
      t_overdue();
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
   end
endmodule